// File: doc/BRIEF.md
# Root Port Power-Up and Link Bring-Up Sequencer

This block walks a PCIe root port from cold reset to an active link with no software involvement. After a start pulse it holds the endpoint in reset and brings up the PHY. It then cycles the controller core reset with clocks running, applies the root-complex mode and power-management settings, and powers the PHY on. After a long hold it lets the endpoint out of reset and enables link training. Finally it samples the data-link-layer active status a bounded number of times before it settles into a success, timeout or failure outcome.

Every wait is counted in microseconds. A prescaler divides the clock by `CLK_MHZ`, so the same sequence runs at full length on silicon and with shortened settle, hold and poll intervals in simulation. A one-hot step output shows which step is active. If the PHY reports a power-on error, the block undoes the power-up in reverse order. The outcome flags stay set until the next start pulse.

Top module: `rp_bringup_seq`

## Requirements
- R1: After reset the step output is 1 (bit 0, idle). `ep_rst_n`, `phy_init_req`, `phy_pwr_req`, `ctl_clk_en`, `ctl_rst`, `ltssm_en`, `link_done`, `link_tout`, `seq_fail` and `axi_wr_halt` are 0. `port_mode` is 0. `phy_test_pd`, `pd_mux_en` and `l1_block` are 1.
- R2: The step output is one-hot, and a successful run visits these bit positions in order: 1 endpoint reset, 2 PHY init, 3 init settle, 4 core reset, 5 reset settle, 6 mode set, 7 PHY power-on, 8 hold, 9 endpoint release, 10 training enable, 11 sample, 12 sample wait, 13 link up. In step 4, `ctl_rst` and `ctl_clk_en` are both 1 and `ep_rst_n` is 0.
- R3: Steps 1, 3, 4, 5 and 9 each last SETTLE_US×CLK_MHZ+1 cycles. Step 8 lasts HOLD_US×CLK_MHZ+1 cycles and step 12 lasts POLL_US×CLK_MHZ+1 cycles. Steps 6, 10, 11 and 15 to 18 last one cycle each.
- R4: Step 2 raises `phy_init_req` and waits there until `phy_init_done` is 1.
- R5: From step 6 onward, `port_mode` is 4 (root complex), `axi_wr_halt` is 1, and `phy_test_pd`, `pd_mux_en` and `l1_block` are 0. All of these hold before `phy_pwr_req` rises.
- R6: `ep_rst_n` rises only when step 9 is entered, which is after the hold. `ltssm_en` is still 0 in step 9. It rises in step 10, which is the final configuration step, and only while `ep_rst_n` is 1.
- R7: In step 11 `link_active` is sampled. If it is 1, the next step is 13 and `link_done` is 1. If it is 0, step 12 follows.
- R8: After POLL_TRIES samples that all read 0, and the wait that follows the last one, the block enters step 14 with `link_tout` set to 1.
- R9: If `phy_pwr_err` is 1 in step 7, the block unwinds through steps 15 to 19, one cycle each. In step 15 `ctl_rst` is 1. In step 16 `ctl_clk_en` is 0. In step 17 `phy_pwr_req` is 0. In step 18 `phy_init_req` is 0. Step 19 holds with `seq_fail` set to 1.
- R10: `start` has no effect in any step other than 0, 13, 14 and 19. The flags `link_done`, `link_tout` and `seq_fail` stay set until a start pulse, which sends the block back to step 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a bring-up sequence when idle or finished |
| phy_init_done | input | 1 | PHY acknowledges initialisation |
| phy_pwr_done | input | 1 | PHY acknowledges power-on |
| phy_pwr_err | input | 1 | PHY reports a power-on failure |
| link_active | input | 1 | Data-link-layer link active status |
| ep_rst_n | output | 1 | Endpoint reset, active low |
| phy_init_req | output | 1 | PHY initialisation request (level) |
| phy_pwr_req | output | 1 | PHY power-on request (level) |
| ctl_clk_en | output | 1 | Controller clock enable |
| ctl_rst | output | 1 | Controller bulk reset |
| port_mode | output | MODE_W | Device type value, 4 for root complex once set |
| phy_test_pd | output | 1 | PHY test power-down control |
| pd_mux_en | output | 1 | MAC/PHY powerdown mux enable |
| l1_block | output | 1 | Blocks L1 entry requests |
| axi_wr_halt | output | 1 | AXI master write-address halt enable |
| ltssm_en | output | 1 | Link training enable |
| link_done | output | 1 | Link came up (sticky) |
| link_tout | output | 1 | Link poll timed out (sticky) |
| seq_fail | output | 1 | PHY power-on failed, unwind complete (sticky) |
| step_oh | output | NSTEP | One-hot current step |

## Verification
The properties assume that the PHY acknowledges are only meaningful while the matching request is high. They also assume that `phy_pwr_err` and `phy_pwr_done` are never both raised for the same request, and that `link_active` behaves as a level sampled in one cycle. The bench's PHY responders answer only after a request has been high for a few cycles and drop their answer as soon as the request falls. The link model raises `link_active` only after a chosen number of sample windows. A stray start pulse is injected only during the hold step, where the requirement says it must be ignored.

// File: rtl/rp_seq_pkg.sv
package rp_seq_pkg;

   localparam int NSTEP = 20;

   typedef enum logic [4:0] {
      ST_IDLE        = 5'd0,
      ST_EP_RST      = 5'd1,
      ST_PHY_INIT    = 5'd2,
      ST_INIT_SETTLE = 5'd3,
      ST_CORE_RST    = 5'd4,
      ST_RST_SETTLE  = 5'd5,
      ST_MODE_CFG    = 5'd6,
      ST_PHY_PWR     = 5'd7,
      ST_HOLD        = 5'd8,
      ST_EP_REL      = 5'd9,
      ST_TRAIN       = 5'd10,
      ST_SAMPLE      = 5'd11,
      ST_SAMPLE_WAIT = 5'd12,
      ST_LINK_UP     = 5'd13,
      ST_LINK_TOUT   = 5'd14,
      ST_UW_RST      = 5'd15,
      ST_UW_CLK      = 5'd16,
      ST_UW_PWR      = 5'd17,
      ST_UW_EXIT     = 5'd18,
      ST_FAILED      = 5'd19
   } step_e;

   // Bit mask covering step indexes lo..hi inclusive.
   function automatic logic [NSTEP-1:0] step_span(input int lo, input int hi);
      logic [NSTEP-1:0] m;
      m = '0;
      for (int i = 0; i < NSTEP; i++) begin
         if (i >= lo && i <= hi) m[i] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/rp_us_tick.sv
module rp_us_tick #(
   parameter int CLK_MHZ = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic tick
);
   generate
      if (CLK_MHZ == 1) begin : g_direct
         assign tick = 1'b1;
      end else begin : g_div
         localparam int PW = $clog2(CLK_MHZ);
         localparam logic [PW-1:0] LAST = PW'(CLK_MHZ - 1);
         logic [PW-1:0] pre_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              pre_q <= '0;
            else if (restart)        pre_q <= '0;
            else if (pre_q == LAST)  pre_q <= '0;
            else                     pre_q <= pre_q + 1'b1;
         end

         assign tick = (pre_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/rp_wait_timer.sv
module rp_wait_timer #(
   parameter int US_W = 17
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [US_W-1:0] load_us,
   input  logic            tick,
   output logic            expired
);
   logic [US_W-1:0] us_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     us_q <= '0;
      else if (load)                  us_q <= load_us;
      else if (tick && us_q != '0)    us_q <= us_q - 1'b1;
   end

   assign expired = (us_q == '0);
endmodule

// File: rtl/rp_step_fsm.sv
module rp_step_fsm
   import rp_seq_pkg::*;
#(
   parameter int US_W       = 17,
   parameter int SETTLE_US  = 1000,
   parameter int HOLD_US    = 100000,
   parameter int POLL_US    = 100000,
   parameter int POLL_TRIES = 10
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            phy_init_done,
   input  logic            phy_pwr_done,
   input  logic            phy_pwr_err,
   input  logic            link_active,
   input  logic            wait_over,
   output step_e           cur,
   output logic            tmr_load,
   output logic [US_W-1:0] tmr_us
);
   localparam int TRY_W = $clog2(POLL_TRIES + 1);
   localparam logic [TRY_W-1:0] TRY_LAST = TRY_W'(POLL_TRIES);

   step_e           cur_q, nxt;
   logic [TRY_W-1:0] tries_q;

   always_comb begin
      nxt = cur_q;
      unique case (cur_q)
         ST_IDLE, ST_LINK_UP, ST_LINK_TOUT, ST_FAILED:
            if (start) nxt = ST_EP_RST;
         ST_EP_RST:      if (wait_over) nxt = ST_PHY_INIT;
         ST_PHY_INIT:    if (phy_init_done) nxt = ST_INIT_SETTLE;
         ST_INIT_SETTLE: if (wait_over) nxt = ST_CORE_RST;
         ST_CORE_RST:    if (wait_over) nxt = ST_RST_SETTLE;
         ST_RST_SETTLE:  if (wait_over) nxt = ST_MODE_CFG;
         ST_MODE_CFG:    nxt = ST_PHY_PWR;
         ST_PHY_PWR: begin
            if (phy_pwr_err)       nxt = ST_UW_RST;
            else if (phy_pwr_done) nxt = ST_HOLD;
         end
         ST_HOLD:        if (wait_over) nxt = ST_EP_REL;
         ST_EP_REL:      if (wait_over) nxt = ST_TRAIN;
         ST_TRAIN:       nxt = ST_SAMPLE;
         ST_SAMPLE:      nxt = link_active ? ST_LINK_UP : ST_SAMPLE_WAIT;
         ST_SAMPLE_WAIT: begin
            if (wait_over) nxt = (tries_q == TRY_LAST) ? ST_LINK_TOUT : ST_SAMPLE;
         end
         ST_UW_RST:      nxt = ST_UW_CLK;
         ST_UW_CLK:      nxt = ST_UW_PWR;
         ST_UW_PWR:      nxt = ST_UW_EXIT;
         ST_UW_EXIT:     nxt = ST_FAILED;
         default:        nxt = ST_IDLE;
      endcase
   end

   always_comb begin
      unique case (nxt)
         ST_EP_RST, ST_INIT_SETTLE, ST_CORE_RST,
         ST_RST_SETTLE, ST_EP_REL:   tmr_us = US_W'(SETTLE_US);
         ST_HOLD:                     tmr_us = US_W'(HOLD_US);
         ST_SAMPLE_WAIT:              tmr_us = US_W'(POLL_US);
         default:                     tmr_us = '0;
      endcase
   end

   assign tmr_load = (nxt != cur_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q   <= ST_IDLE;
         tries_q <= '0;
      end else begin
         cur_q <= nxt;
         if (nxt == ST_EP_RST)
            tries_q <= '0;
         else if (cur_q == ST_SAMPLE && !link_active)
            tries_q <= tries_q + 1'b1;
      end
   end

   assign cur = cur_q;
endmodule

// File: rtl/rp_port_drive.sv
module rp_port_drive
   import rp_seq_pkg::*;
#(
   parameter int          MODE_W  = 4,
   parameter logic [3:0]  MODE_RC = 4'h4
) (
   input  step_e             cur,
   output logic [NSTEP-1:0]  step_oh,
   output logic              ep_rst_n,
   output logic              phy_init_req,
   output logic              phy_pwr_req,
   output logic              ctl_clk_en,
   output logic              ctl_rst,
   output logic [MODE_W-1:0] port_mode,
   output logic              phy_test_pd,
   output logic              pd_mux_en,
   output logic              l1_block,
   output logic              axi_wr_halt,
   output logic              ltssm_en,
   output logic              link_done,
   output logic              link_tout,
   output logic              seq_fail
);
   localparam logic [NSTEP-1:0] M_EP_OUT = step_span(int'(ST_EP_REL), int'(ST_LINK_TOUT));
   localparam logic [NSTEP-1:0] M_INIT   = step_span(int'(ST_PHY_INIT), int'(ST_UW_PWR));
   localparam logic [NSTEP-1:0] M_PWR    = step_span(int'(ST_PHY_PWR), int'(ST_UW_CLK));
   localparam logic [NSTEP-1:0] M_CLK    = step_span(int'(ST_CORE_RST), int'(ST_UW_RST));
   localparam logic [NSTEP-1:0] M_RST    = step_span(int'(ST_CORE_RST), int'(ST_CORE_RST))
                                         | step_span(int'(ST_UW_RST), int'(ST_FAILED));
   localparam logic [NSTEP-1:0] M_CFG    = step_span(int'(ST_MODE_CFG), int'(ST_FAILED));
   localparam logic [NSTEP-1:0] M_TRAIN  = step_span(int'(ST_TRAIN), int'(ST_LINK_TOUT));

   logic cfg_on;

   assign step_oh      = NSTEP'(1) << cur;
   assign ep_rst_n     = |(step_oh & M_EP_OUT);
   assign phy_init_req = |(step_oh & M_INIT);
   assign phy_pwr_req  = |(step_oh & M_PWR);
   assign ctl_clk_en   = |(step_oh & M_CLK);
   assign ctl_rst      = |(step_oh & M_RST);
   assign ltssm_en     = |(step_oh & M_TRAIN);
   assign cfg_on       = |(step_oh & M_CFG);

   assign port_mode    = cfg_on ? MODE_W'(MODE_RC) : '0;
   assign phy_test_pd  = ~cfg_on;
   assign pd_mux_en    = ~cfg_on;
   assign l1_block     = ~cfg_on;
   assign axi_wr_halt  = cfg_on;

   assign link_done    = step_oh[ST_LINK_UP];
   assign link_tout    = step_oh[ST_LINK_TOUT];
   assign seq_fail     = step_oh[ST_FAILED];
endmodule

// File: rtl/rp_bringup_seq.sv
module rp_bringup_seq
   import rp_seq_pkg::*;
#(
   parameter int         CLK_MHZ    = 100,
   parameter int         SETTLE_US  = 1000,
   parameter int         HOLD_US    = 100000,
   parameter int         POLL_US    = 100000,
   parameter int         POLL_TRIES = 10,
   parameter int         MODE_W     = 4,
   parameter logic [3:0] MODE_RC    = 4'h4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              phy_init_done,
   input  logic              phy_pwr_done,
   input  logic              phy_pwr_err,
   input  logic              link_active,
   output logic              ep_rst_n,
   output logic              phy_init_req,
   output logic              phy_pwr_req,
   output logic              ctl_clk_en,
   output logic              ctl_rst,
   output logic [MODE_W-1:0] port_mode,
   output logic              phy_test_pd,
   output logic              pd_mux_en,
   output logic              l1_block,
   output logic              axi_wr_halt,
   output logic              ltssm_en,
   output logic              link_done,
   output logic              link_tout,
   output logic              seq_fail,
   output logic [NSTEP-1:0]  step_oh
);
   localparam int MAX_US = (HOLD_US > POLL_US)
                         ? ((HOLD_US > SETTLE_US) ? HOLD_US : SETTLE_US)
                         : ((POLL_US > SETTLE_US) ? POLL_US : SETTLE_US);
   localparam int US_W = $clog2(MAX_US + 1);

   generate
      if (CLK_MHZ < 1)    begin : g_bad_clk   $error("CLK_MHZ must be at least 1"); end
      if (SETTLE_US < 1)  begin : g_bad_set   $error("SETTLE_US must be at least 1"); end
      if (HOLD_US < 1)    begin : g_bad_hold  $error("HOLD_US must be at least 1"); end
      if (POLL_US < 1)    begin : g_bad_poll  $error("POLL_US must be at least 1"); end
      if (POLL_TRIES < 1) begin : g_bad_tries $error("POLL_TRIES must be at least 1"); end
      if (MODE_W < 3)     begin : g_bad_mode  $error("MODE_W must hold the root-complex code"); end
   endgenerate

   step_e           cur;
   logic            tmr_load, tick, wait_over;
   logic [US_W-1:0] tmr_us;

   rp_us_tick #(.CLK_MHZ(CLK_MHZ)) u_tick (
      .clk(clk), .rst_n(rst_n), .restart(tmr_load), .tick(tick)
   );

   rp_wait_timer #(.US_W(US_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_us(tmr_us),
      .tick(tick), .expired(wait_over)
   );

   rp_step_fsm #(
      .US_W(US_W), .SETTLE_US(SETTLE_US), .HOLD_US(HOLD_US),
      .POLL_US(POLL_US), .POLL_TRIES(POLL_TRIES)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .start(start),
      .phy_init_done(phy_init_done), .phy_pwr_done(phy_pwr_done),
      .phy_pwr_err(phy_pwr_err), .link_active(link_active),
      .wait_over(wait_over), .cur(cur), .tmr_load(tmr_load), .tmr_us(tmr_us)
   );

   rp_port_drive #(.MODE_W(MODE_W), .MODE_RC(MODE_RC)) u_drive (
      .cur(cur), .step_oh(step_oh), .ep_rst_n(ep_rst_n),
      .phy_init_req(phy_init_req), .phy_pwr_req(phy_pwr_req),
      .ctl_clk_en(ctl_clk_en), .ctl_rst(ctl_rst), .port_mode(port_mode),
      .phy_test_pd(phy_test_pd), .pd_mux_en(pd_mux_en), .l1_block(l1_block),
      .axi_wr_halt(axi_wr_halt), .ltssm_en(ltssm_en), .link_done(link_done),
      .link_tout(link_tout), .seq_fail(seq_fail)
   );
endmodule

// File: rtl/rp_bringup_chk.sv
module rp_bringup_chk #(
   parameter int         MODE_W  = 4,
   parameter logic [3:0] MODE_RC = 4'h4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              link_active,
   input logic              ep_rst_n,
   input logic              phy_init_req,
   input logic              phy_pwr_req,
   input logic              ctl_clk_en,
   input logic              ctl_rst,
   input logic [MODE_W-1:0] port_mode,
   input logic              phy_test_pd,
   input logic              axi_wr_halt,
   input logic              ltssm_en,
   input logic              link_done,
   input logic              link_tout,
   input logic              seq_fail
);
   p_core_rst_ep_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_rst |-> !ep_rst_n);

   p_cfg_before_pwr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(phy_pwr_req) |-> (port_mode == MODE_W'(MODE_RC) && !phy_test_pd && axi_wr_halt));

   p_ep_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ep_rst_n) |-> (phy_pwr_req && !ltssm_en));

   p_train_needs_ep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ltssm_en |-> ep_rst_n);

   p_done_on_link_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(link_done) |-> $past(link_active));

   p_unwind_clk_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ctl_rst) && phy_pwr_req) |=> (!ctl_clk_en && phy_pwr_req));

   p_unwind_pwr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ctl_clk_en) && ctl_rst) |=> (!phy_pwr_req && phy_init_req));

   p_unwind_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(phy_pwr_req) && ctl_rst) |=> !phy_init_req);

   p_flags_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({link_done, link_tout, seq_fail}) <= 1);

   p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (link_done && !start) |=> link_done);

   p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ltssm_en && start && !link_done && !link_tout) |=> ltssm_en);
endmodule

bind rp_bringup_seq rp_bringup_chk #(.MODE_W(MODE_W), .MODE_RC(MODE_RC)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .link_active(link_active),
   .ep_rst_n(ep_rst_n), .phy_init_req(phy_init_req), .phy_pwr_req(phy_pwr_req),
   .ctl_clk_en(ctl_clk_en), .ctl_rst(ctl_rst), .port_mode(port_mode),
   .phy_test_pd(phy_test_pd), .axi_wr_halt(axi_wr_halt), .ltssm_en(ltssm_en),
   .link_done(link_done), .link_tout(link_tout), .seq_fail(seq_fail)
);

// File: tb/sim_rp_bringup_seq.sv
module sim_rp_bringup_seq;
   localparam int M = 2, S = 3, H = 10, P = 4, T = 3, NS = 20;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic phy_init_done = 1'b0, phy_pwr_done = 1'b0, phy_pwr_err = 1'b0;
   logic link_active;
   logic ep_rst_n, phy_init_req, phy_pwr_req, ctl_clk_en, ctl_rst;
   logic [3:0] port_mode;
   logic phy_test_pd, pd_mux_en, l1_block, axi_wr_halt, ltssm_en;
   logic link_done, link_tout, seq_fail;
   logic [NS-1:0] step_oh;

   int n_chk = 0, n_bad = 0;
   int exp_q[$];
   int link_k = 0, poll_seen = 0;
   bit pwr_fail = 1'b0, run_on = 1'b0;

   always #2 clk = ~clk;

   assign link_active = run_on && (poll_seen >= link_k);

   rp_bringup_seq #(.CLK_MHZ(M), .SETTLE_US(S), .HOLD_US(H), .POLL_US(P),
                    .POLL_TRIES(T)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .phy_init_done(phy_init_done),
      .phy_pwr_done(phy_pwr_done), .phy_pwr_err(phy_pwr_err),
      .link_active(link_active), .ep_rst_n(ep_rst_n), .phy_init_req(phy_init_req),
      .phy_pwr_req(phy_pwr_req), .ctl_clk_en(ctl_clk_en), .ctl_rst(ctl_rst),
      .port_mode(port_mode), .phy_test_pd(phy_test_pd), .pd_mux_en(pd_mux_en),
      .l1_block(l1_block), .axi_wr_halt(axi_wr_halt), .ltssm_en(ltssm_en),
      .link_done(link_done), .link_tout(link_tout), .seq_fail(seq_fail),
      .step_oh(step_oh)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int step_idx(input logic [NS-1:0] v);
      for (int i = 0; i < NS; i++) if (v[i]) return i;
      return -1;
   endfunction

   // R3: expected cycles spent in each step, -1 where it depends on stimulus
   function automatic int dwell_of(input int i);
      case (i)
         1, 3, 4, 5, 9: return S * M + 1;
         8:             return H * M + 1;
         12:            return P * M + 1;
         6, 10, 11, 15, 16, 17, 18: return 1;
         default:       return -1;
      endcase
   endfunction

   // PHY responders
   initial begin
      int ic = 0, pc = 0;
      forever begin
         @(negedge clk);
         if (phy_init_req) begin ic++; if (ic >= 3) phy_init_done = 1'b1; end
         else begin ic = 0; phy_init_done = 1'b0; end
         if (phy_pwr_req) begin
            pc++;
            if (pc >= 2) begin
               phy_pwr_done = !pwr_fail;
               phy_pwr_err  = pwr_fail;
            end
         end else begin pc = 0; phy_pwr_done = 1'b0; phy_pwr_err = 1'b0; end
      end
   end

   // Monitor: compare step order, dwell and per-step outputs against the scoreboard
   initial begin
      int prev = 0, dwell = 0, now, exp, want;
      forever begin
         @(negedge clk);
         if (rst_n) begin
            now = step_idx(step_oh);
            if (now == prev) dwell++;
            else begin
               want = dwell_of(prev);
               if (want >= 0) chk(dwell == want, "R3 step dwell", dwell, want);
               chk($countones(step_oh) == 1, "R2 one-hot step", $countones(step_oh), 1);
               if (exp_q.size() == 0) chk(1'b0, "R2 unexpected step", now, -1);
               else begin
                  exp = exp_q.pop_front();
                  chk(now == exp, "R2 step order", now, exp);
               end
               case (now)
                  4:  chk(ctl_rst && ctl_clk_en && !ep_rst_n, "R2 core reset outputs",
                          {ctl_rst, ctl_clk_en, ep_rst_n}, 3'b110);
                  7:  chk(port_mode == 4 && !phy_test_pd && !pd_mux_en && !l1_block && axi_wr_halt,
                          "R5 mode before power-on", {port_mode, phy_test_pd, pd_mux_en, l1_block, axi_wr_halt},
                          {4'd4, 4'b0001});
                  8:  chk(!ep_rst_n, "R6 endpoint held in hold", ep_rst_n, 0);
                  9:  chk(ep_rst_n && !ltssm_en, "R6 release before training",
                          {ep_rst_n, ltssm_en}, 2'b10);
                  10: chk(ltssm_en && ep_rst_n, "R6 training enabled last",
                          {ltssm_en, ep_rst_n}, 2'b11);
                  12: poll_seen++;
                  15: chk(ctl_rst && ctl_clk_en, "R9 unwind reset first", {ctl_rst, ctl_clk_en}, 2'b11);
                  16: chk(ctl_rst && !ctl_clk_en && phy_pwr_req, "R9 unwind clocks",
                          {ctl_rst, ctl_clk_en, phy_pwr_req}, 3'b101);
                  17: chk(!phy_pwr_req && phy_init_req, "R9 unwind power",
                          {phy_pwr_req, phy_init_req}, 2'b01);
                  18: chk(!phy_init_req, "R9 unwind exit", phy_init_req, 0);
                  default: ;
               endcase
               prev = now;
               dwell = 1;
            end
         end
      end
   end

   // Driver: push expected steps, then stimulate
   task automatic run_case(input int k, input bit fail, input bit poke);
      link_k = k; pwr_fail = fail; poll_seen = 0; run_on = 1'b1;
      for (int i = 1; i <= 7; i++) exp_q.push_back(i);
      if (fail) begin
         for (int i = 15; i <= 19; i++) exp_q.push_back(i);
      end else begin
         exp_q.push_back(8); exp_q.push_back(9); exp_q.push_back(10);
         for (int i = 0; i < ((k < T) ? k : T); i++) begin
            exp_q.push_back(11); exp_q.push_back(12);
         end
         if (k < T) begin exp_q.push_back(11); exp_q.push_back(13); end
         else exp_q.push_back(14);
      end
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      if (poke) begin
         wait (step_oh[8]);
         @(negedge clk) start = 1'b1;   // R10: ignored mid-sequence
         @(negedge clk) start = 1'b0;
      end
      wait (step_oh[13] || step_oh[14] || step_oh[19]);
      repeat (2) @(negedge clk);
      chk(exp_q.size() == 0, "R2 all steps seen", exp_q.size(), 0);
      exp_q.delete();
      if (fail) chk(seq_fail && !link_done && !link_tout, "R9 fail flag",
                    {seq_fail, link_done, link_tout}, 3'b100);
      else if (k < T) chk(link_done && !link_tout && !seq_fail, "R7 link up flag",
                          {link_done, link_tout, seq_fail}, 3'b100);
      else chk(link_tout && !link_done && !seq_fail, "R8 timeout flag",
               {link_tout, link_done, seq_fail}, 3'b100);
      repeat (20) @(negedge clk);
      chk((link_done | link_tout | seq_fail) == 1'b1, "R10 flag sticky",
          link_done | link_tout | seq_fail, 1);
      run_on = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(step_oh == 1 && !ep_rst_n && !phy_init_req && !phy_pwr_req && !ctl_clk_en
          && !ctl_rst && !ltssm_en && !link_done && !link_tout && !seq_fail,
          "R1 reset controls", step_oh, 1);
      chk(port_mode == 0 && phy_test_pd && pd_mux_en && l1_block && !axi_wr_halt,
          "R1 reset mode levels", {port_mode, phy_test_pd, pd_mux_en, l1_block, axi_wr_halt},
          {4'd0, 4'b1110});
      rst_n = 1'b1;
      @(negedge clk);
      // R4: PHY init step waits on acknowledge (responder answers after 3 cycles)
      run_case(0, 1'b0, 1'b0);
      run_case(2, 1'b0, 1'b1);
      run_case(T, 1'b0, 1'b0);
      run_case(0, 1'b1, 1'b0);
      run_case(1, 1'b0, 1'b0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule